// File: doc/BRIEF.md
# Slowdown-Balancing Fair Memory Arbiter

This block chooses one request per cycle out of a small memory request buffer shared by several hardware threads. Alongside the buffer it receives two counters per thread: the stall time the thread has accumulated while sharing memory, and an externally produced estimate of the stall time it would have seen running alone. The ratio of the two is the thread's slowdown. Among threads that currently hold at least one buffered request, the arbiter finds the most and the least slowed-down thread and forms their ratio, the unfairness.

When unfairness stays under a programmable threshold, the arbiter serves for throughput: row-buffer hits first, then the oldest request. Once unfairness reaches the threshold, the requests of the most slowed-down thread are preferred over everything else, with row-hit and age ordering below that. All ratio comparisons are done by cross-multiplication, so no divider exists; the threshold is given in sixteenths. The decision is registered, so the grant for the buffer contents presented before a clock edge appears right after that edge.

Top module: `slowdown_fair_arbiter`

## Requirements
- R1: The outputs are registered: after a rising edge, `grantValid` is 1 exactly when at least one `reqValid` bit was 1 before that edge; with no valid entry, `grantValid` and `fairMode` are 0.
- R2: A thread's slowdown is `sharedStall / aloneStall` for that thread, and an `aloneStall` of 0 is used as 1.
- R3: With two or more legal threads (threads owning a valid entry), `fairMode` is 1 exactly when `sMax*aMin*16 >= unfairThresh*sMin*aMax`, where s and a are the shared and (adjusted) alone stall of the largest- and smallest-slowdown legal threads; a smallest slowdown of zero therefore always selects fairness.
- R4: With exactly one legal thread, unfairness is taken as 1, so `fairMode` is 1 exactly when `unfairThresh <= 16`.
- R5: With `fairMode` 0, the grant goes to a valid entry with `reqRowHit` 1 if any, then to the largest `reqAge` (larger means older), then to the lowest entry index.
- R6: With `fairMode` 1, the grant goes first to a valid entry owned by the largest-slowdown thread, then by the R5 order.
- R7: When several legal threads share the largest (or smallest) slowdown, the lowest thread index is taken.
- R8: While `rst_n` is 0 and on the first cycle after its release, `grantValid`, `grantIdx` and `fairMode` are 0.
- R9: The stall counters of threads without a valid entry influence neither `fairMode` nor the grant.
- R10: A granted index always names an entry that was valid before the edge that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | BUF_DEPTH | Per-entry valid bit |
| reqThread | input | BUF_DEPTH*TID_W | Owning thread of each entry, entry e in bits [e*TID_W +: TID_W] |
| reqRowHit | input | BUF_DEPTH | Entry targets the open row |
| reqAge | input | BUF_DEPTH*AGE_W | Entry age, larger is older, entry e in bits [e*AGE_W +: AGE_W] |
| sharedStall | input | NUM_THREADS*STALL_W | Shared stall time, thread t in bits [t*STALL_W +: STALL_W] |
| aloneStall | input | NUM_THREADS*STALL_W | Estimated alone stall time, same layout |
| unfairThresh | input | THR_W | Unfairness threshold in 1/16 units |
| grantValid | output | 1 | A grant is presented |
| grantIdx | output | IDX_W | Granted buffer entry |
| fairMode | output | 1 | Fairness ordering was used for this grant |

## Verification
The policy switch and the row-hit preference collide whenever unfairness reaches the threshold in the same cycle that an entry from some other thread is a row hit: the two orderings then name different entries. The bench provokes this by setting the stall counters so the max/min ratio lands exactly on the threshold and one sixteenth away from it, with an older row-hit entry from the less slowed-down thread placed beside a miss from the most slowed-down thread. A behavioural model predicts mode and grant for every cycle, including a long randomized run with small counter values that forces slowdown ties and zero alone estimates.

// File: rtl/fair_arb_pkg.sv
package fair_arb_pkg;
  // Strobes from the policy control to the grant datapath.
  typedef struct packed {
    logic fairPolicy;   // order by max-slowdown thread first
    logic grantLoad;    // capture a new grant
    logic grantClear;   // nothing to grant this cycle
  } arbStrobe_t;
endpackage

// File: rtl/fair_arb_slowdown.sv
module fair_arb_slowdown #(
  parameter int NUM_THREADS = 4,
  parameter int STALL_W     = 16,
  parameter int THR_W       = 8,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0]         threadLegal,
  input  logic [NUM_THREADS*STALL_W-1:0] sharedStall,
  input  logic [NUM_THREADS*STALL_W-1:0] aloneStall,
  input  logic [THR_W-1:0]               unfairThresh,
  output logic                           anyLegal,
  output logic [TID_W-1:0]               maxThread,
  output logic                           unfairHit
);
  localparam int PROD_W = 2 * STALL_W;
  localparam int CMP_W  = PROD_W + THR_W + 4;

  logic [STALL_W-1:0] shr [NUM_THREADS];
  logic [STALL_W-1:0] aln [NUM_THREADS];

  // Unpack per-thread counters; a zero alone estimate behaves as one.
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_unpack
    assign shr[t] = sharedStall[t*STALL_W +: STALL_W];
    assign aln[t] = (aloneStall[t*STALL_W +: STALL_W] == '0)
                    ? STALL_W'(1) : aloneStall[t*STALL_W +: STALL_W];
  end

  logic [TID_W-1:0]  minThread;
  logic [TID_W-1:0]  hiT;
  logic [TID_W-1:0]  loT;
  logic              seen;
  logic [CMP_W-1:0]  lhs;
  logic [CMP_W-1:0]  rhs;

  always_comb begin
    hiT  = '0;
    loT  = '0;
    seen = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (threadLegal[t]) begin
        if (!seen) begin
          hiT  = TID_W'(t);
          loT  = TID_W'(t);
          seen = 1'b1;
        end else begin
          // strict compares keep the lowest index on ties
          if (PROD_W'(shr[t]) * PROD_W'(aln[hiT]) > PROD_W'(shr[hiT]) * PROD_W'(aln[t]))
            hiT = TID_W'(t);
          if (PROD_W'(shr[t]) * PROD_W'(aln[loT]) < PROD_W'(shr[loT]) * PROD_W'(aln[t]))
            loT = TID_W'(t);
        end
      end
    end
    maxThread = hiT;
    minThread = loT;
    anyLegal  = seen;
    lhs = CMP_W'(PROD_W'(shr[hiT]) * PROD_W'(aln[loT])) << 4;
    rhs = CMP_W'(unfairThresh) * CMP_W'(PROD_W'(shr[loT]) * PROD_W'(aln[hiT]));
    if (!seen)
      unfairHit = 1'b0;
    else if ($countones(threadLegal) == 1)
      unfairHit = (CMP_W'(unfairThresh) <= CMP_W'(16));
    else
      unfairHit = (lhs >= rhs);
  end

  logic unusedMin;
  assign unusedMin = ^minThread;
endmodule

// File: rtl/fair_arb_ctrl.sv
module fair_arb_ctrl
  import fair_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       anyLegal,
  input  logic       unfairHit,
  output arbStrobe_t strobe,
  output logic       fairMode
);
  always_comb begin
    strobe.fairPolicy = anyLegal & unfairHit;
    strobe.grantLoad  = anyLegal;
    strobe.grantClear = ~anyLegal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fairMode <= 1'b0;
    else        fairMode <= strobe.fairPolicy;
  end
endmodule

// File: rtl/fair_arb_datapath.sv
module fair_arb_datapath
  import fair_arb_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int BUF_DEPTH   = 8,
  parameter int AGE_W       = 8,
  parameter int TID_W       = 2,
  parameter int IDX_W       = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  arbStrobe_t                 strobe,
  input  logic [TID_W-1:0]           maxThread,
  input  logic [BUF_DEPTH-1:0]       reqValid,
  input  logic [BUF_DEPTH*TID_W-1:0] reqThread,
  input  logic [BUF_DEPTH-1:0]       reqRowHit,
  input  logic [BUF_DEPTH*AGE_W-1:0] reqAge,
  output logic [NUM_THREADS-1:0]     threadLegal,
  output logic                       grantValid,
  output logic [IDX_W-1:0]           grantIdx
);
  localparam int KEY_W = AGE_W + 2;

  // Which threads own at least one valid entry.
  always_comb begin
    threadLegal = '0;
    for (int e = 0; e < BUF_DEPTH; e++) begin
      if (reqValid[e] && (int'(reqThread[e*TID_W +: TID_W]) < NUM_THREADS))
        threadLegal[reqThread[e*TID_W +: TID_W]] = 1'b1;
    end
  end

  // Priority key per entry: {favoured thread, row hit, age}.
  logic [KEY_W-1:0] entryKey [BUF_DEPTH];
  for (genvar e = 0; e < BUF_DEPTH; e++) begin : g_key
    assign entryKey[e] = {strobe.fairPolicy && (reqThread[e*TID_W +: TID_W] == maxThread),
                          reqRowHit[e], reqAge[e*AGE_W +: AGE_W]};
  end

  logic [KEY_W-1:0] bestKey;
  logic [IDX_W-1:0] bestIdx;
  logic             bestSeen;

  always_comb begin
    bestKey  = '0;
    bestIdx  = '0;
    bestSeen = 1'b0;
    for (int e = 0; e < BUF_DEPTH; e++) begin
      if (reqValid[e] && (!bestSeen || entryKey[e] > bestKey)) begin
        bestKey  = entryKey[e];
        bestIdx  = IDX_W'(e);
        bestSeen = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.grantClear) begin
      grantValid <= 1'b0;
      grantIdx   <= '0;
    end else if (strobe.grantLoad) begin
      grantValid <= bestSeen;
      grantIdx   <= bestIdx;
    end
  end
endmodule

// File: rtl/slowdown_fair_arbiter.sv
module slowdown_fair_arbiter
  import fair_arb_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int BUF_DEPTH   = 8,
  parameter int STALL_W     = 16,
  parameter int AGE_W       = 8,
  parameter int THR_W       = 8,
  parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  parameter int IDX_W       = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [BUF_DEPTH-1:0]         reqValid,
  input  logic [BUF_DEPTH*TID_W-1:0]   reqThread,
  input  logic [BUF_DEPTH-1:0]         reqRowHit,
  input  logic [BUF_DEPTH*AGE_W-1:0]   reqAge,
  input  logic [NUM_THREADS*STALL_W-1:0] sharedStall,
  input  logic [NUM_THREADS*STALL_W-1:0] aloneStall,
  input  logic [THR_W-1:0]             unfairThresh,
  output logic                         grantValid,
  output logic [IDX_W-1:0]             grantIdx,
  output logic                         fairMode
);
  arbStrobe_t             strobe;
  logic [NUM_THREADS-1:0] threadLegal;
  logic [TID_W-1:0]       maxThread;
  logic                   anyLegal;
  logic                   unfairHit;

  fair_arb_slowdown #(
    .NUM_THREADS(NUM_THREADS), .STALL_W(STALL_W), .THR_W(THR_W), .TID_W(TID_W)
  ) u_slow (
    .threadLegal(threadLegal), .sharedStall(sharedStall), .aloneStall(aloneStall),
    .unfairThresh(unfairThresh), .anyLegal(anyLegal), .maxThread(maxThread),
    .unfairHit(unfairHit)
  );

  fair_arb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .anyLegal(anyLegal), .unfairHit(unfairHit),
    .strobe(strobe), .fairMode(fairMode)
  );

  fair_arb_datapath #(
    .NUM_THREADS(NUM_THREADS), .BUF_DEPTH(BUF_DEPTH), .AGE_W(AGE_W),
    .TID_W(TID_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .maxThread(maxThread),
    .reqValid(reqValid), .reqThread(reqThread), .reqRowHit(reqRowHit),
    .reqAge(reqAge), .threadLegal(threadLegal), .grantValid(grantValid),
    .grantIdx(grantIdx)
  );
endmodule

// File: rtl/slowdown_fair_arbiter_chk.sv
module slowdown_fair_arbiter_chk #(
  parameter int NUM_THREADS = 4,
  parameter int BUF_DEPTH   = 8,
  parameter int STALL_W     = 16,
  parameter int AGE_W       = 8,
  parameter int THR_W       = 8,
  parameter int TID_W       = 2,
  parameter int IDX_W       = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [BUF_DEPTH-1:0]         reqValid,
  input logic [BUF_DEPTH*TID_W-1:0]   reqThread,
  input logic [BUF_DEPTH-1:0]         reqRowHit,
  input logic [BUF_DEPTH*AGE_W-1:0]   reqAge,
  input logic [NUM_THREADS*STALL_W-1:0] sharedStall,
  input logic [NUM_THREADS*STALL_W-1:0] aloneStall,
  input logic [THR_W-1:0]             unfairThresh,
  input logic                         grantValid,
  input logic [IDX_W-1:0]             grantIdx,
  input logic                         fairMode
);
  // Set one edge after reset release, so $past never reaches into reset.
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!grantValid && !fairMode && grantIdx == '0));

  p_grant_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    grantValid == (|$past(reqValid)));

  p_grant_names_valid_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    grantValid |-> ((($past(reqValid) >> grantIdx) & BUF_DEPTH'(1)) != '0));

  p_mode_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    fairMode |-> grantValid);

  p_rowhit_first_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (grantValid && !fairMode && (|($past(reqValid) & $past(reqRowHit))))
      |-> ((($past(reqRowHit) >> grantIdx) & BUF_DEPTH'(1)) != '0));
endmodule

bind slowdown_fair_arbiter slowdown_fair_arbiter_chk #(
  .NUM_THREADS(NUM_THREADS), .BUF_DEPTH(BUF_DEPTH), .STALL_W(STALL_W),
  .AGE_W(AGE_W), .THR_W(THR_W), .TID_W(TID_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/slowdown_fair_arbiter_tb_top.sv
module slowdown_fair_arbiter_tb_top;
  localparam int NT = 4;
  localparam int BD = 8;
  localparam int SW = 16;
  localparam int AW = 8;
  localparam int TW = 8;
  localparam int IW = 2;
  localparam int XW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [BD-1:0]    reqValid = '0;
  logic [BD*IW-1:0] reqThread = '0;
  logic [BD-1:0]    reqRowHit = '0;
  logic [BD*AW-1:0] reqAge = '0;
  logic [NT*SW-1:0] sharedStall = '0;
  logic [NT*SW-1:0] aloneStall = '0;
  logic [TW-1:0]    unfairThresh = '0;
  logic             grantValid;
  logic [XW-1:0]    grantIdx;
  logic             fairMode;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  slowdown_fair_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqThread(reqThread),
    .reqRowHit(reqRowHit), .reqAge(reqAge), .sharedStall(sharedStall),
    .aloneStall(aloneStall), .unfairThresh(unfairThresh),
    .grantValid(grantValid), .grantIdx(grantIdx), .fairMode(fairMode)
  );

  task automatic setEntry(int e, bit v, int th, bit hit, int age);
    reqValid[e] = v;
    reqThread[e*IW +: IW] = IW'(th);
    reqRowHit[e] = hit;
    reqAge[e*AW +: AW] = AW'(age);
  endtask

  task automatic setThread(int t, int sh, int al);
    sharedStall[t*SW +: SW] = SW'(sh);
    aloneStall[t*SW +: SW] = SW'(al);
  endtask

  task automatic clearAll();
    reqValid = '0; reqThread = '0; reqRowHit = '0; reqAge = '0;
    sharedStall = '0; aloneStall = '0;
  endtask

  // Behavioural prediction straight from the requirements.
  task automatic predict(output bit ev, output int ei, output bit ef);
    bit legal [NT];
    longint s [NT];
    longint a [NT];
    int cnt, mx, mn, best;
    longint bestScore, sc;
    cnt = 0; mx = -1; mn = -1;
    for (int t = 0; t < NT; t++) begin
      legal[t] = 0;
      s[t] = sharedStall[t*SW +: SW];
      a[t] = aloneStall[t*SW +: SW];
      if (a[t] == 0) a[t] = 1;
    end
    for (int e = 0; e < BD; e++)
      if (reqValid[e]) legal[reqThread[e*IW +: IW]] = 1;
    for (int t = 0; t < NT; t++) begin
      if (!legal[t]) continue;
      cnt++;
      if (mx < 0 || s[t] * a[mx] > s[mx] * a[t]) mx = t;
      if (mn < 0 || s[t] * a[mn] < s[mn] * a[t]) mn = t;
    end
    ev = (cnt > 0); ei = 0; ef = 0;
    if (cnt == 0) return;
    if (cnt == 1) ef = (unfairThresh <= 16);
    else ef = (s[mx] * a[mn] * 16 >= longint'(unfairThresh) * s[mn] * a[mx]);
    best = -1; bestScore = -1;
    for (int e = 0; e < BD; e++) begin
      if (!reqValid[e]) continue;
      sc = longint'(reqAge[e*AW +: AW]);
      if (reqRowHit[e]) sc += 1000;
      if (ef && int'(reqThread[e*IW +: IW]) == mx) sc += 10000;
      if (sc > bestScore) begin bestScore = sc; best = e; end
    end
    ei = best;
  endtask

  // Apply the current inputs across one edge and compare after it.
  task automatic step(string req);
    bit ev, ef; int ei; bit ok;
    predict(ev, ei, ef);
    @(posedge clk);
    @(negedge clk);
    checks++;
    ok = (grantValid == ev) && (fairMode == ef) && (!ev || int'(grantIdx) == ei);
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual valid=%0d idx=%0d fair=%0d expected valid=%0d idx=%0d fair=%0d",
               req, grantValid, grantIdx, fairMode, ev, ei, ef);
    end
  endtask

  task automatic checkIdle(string req);
    checks++;
    if (grantValid !== 1'b0 || fairMode !== 1'b0 || grantIdx !== '0) begin
      fails++;
      $display("FAIL %s: actual valid=%0d idx=%0d fair=%0d expected 0 0 0",
               req, grantValid, grantIdx, fairMode);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1: watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset holds outputs at zero even with requests pending
    setEntry(0, 1, 0, 1, 5);
    repeat (3) @(negedge clk);
    checkIdle("R8");
    rst_n = 1'b1;
    clearAll();
    @(negedge clk);
    checkIdle("R8");
    // R1: empty buffer gives no grant
    step("R1");

    // R5: row hit beats an older miss
    clearAll(); unfairThresh = 8'd255;
    setThread(0, 1, 1); setThread(1, 1, 1);
    setEntry(2, 1, 0, 0, 200); setEntry(5, 1, 1, 1, 3);
    step("R5");
    // R5: equal row-hit status, older wins
    setEntry(5, 1, 1, 0, 3);
    step("R5");
    // R5: full tie, lowest index
    setEntry(2, 1, 0, 0, 9); setEntry(5, 1, 1, 0, 9);
    step("R5");

    // R2: zero alone estimate treated as one: thread0 slowdown 5, thread1 4
    clearAll(); unfairThresh = 8'd16;
    setThread(0, 5, 0); setThread(1, 4, 1);
    setEntry(0, 1, 0, 0, 1); setEntry(1, 1, 1, 1, 90);
    step("R2");

    // R3: ratio exactly 1.5 (24/16) against threshold 24 and 25
    clearAll();
    setThread(0, 3, 1); setThread(1, 2, 1);
    setEntry(0, 1, 0, 0, 1); setEntry(1, 1, 1, 1, 90);
    unfairThresh = 8'd24;
    step("R3");
    unfairThresh = 8'd25;
    step("R3");
    // R6: fair mode puts the max thread's miss above an older hit
    unfairThresh = 8'd20;
    setEntry(3, 1, 0, 1, 2);
    step("R6");
    // R3: zero smallest slowdown forces fairness
    setThread(1, 0, 7); unfairThresh = 8'd255;
    step("R3");

    // R4: single legal thread, unfairness counted as one
    clearAll();
    setThread(2, 0, 0);
    setEntry(4, 1, 2, 0, 7); setEntry(6, 1, 2, 1, 1);
    unfairThresh = 8'd16;
    step("R4");
    unfairThresh = 8'd17;
    step("R4");

    // R7: equal slowdowns on threads 1 and 2, lowest index favoured
    clearAll(); unfairThresh = 8'd16;
    setThread(1, 4, 2); setThread(2, 2, 1);
    setEntry(0, 1, 2, 1, 99); setEntry(7, 1, 1, 0, 0);
    step("R7");

    // R9: thread 3 has a huge slowdown but no requests
    clearAll();
    setThread(0, 2, 1); setThread(1, 1, 1); setThread(3, 100, 1);
    setEntry(1, 1, 1, 1, 50); setEntry(2, 1, 0, 0, 10);
    unfairThresh = 8'd40;
    step("R9");
    unfairThresh = 8'd32;
    step("R9");

    // R10 and both orderings under random traffic with forced ties
    for (int i = 0; i < 3000; i++) begin
      bit ev, ef; int ei;
      for (int e = 0; e < BD; e++)
        setEntry(e, ($urandom % 3) != 0, $urandom % NT, $urandom % 2, $urandom % 6);
      for (int t = 0; t < NT; t++) setThread(t, $urandom % 12, $urandom % 5);
      unfairThresh = TW'($urandom % 64);
      predict(ev, ei, ef);
      if (!ev) step("R1");
      else if (ef) step("R6");
      else step("R10");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule